// File: doc/BRIEF.md
# Scanline Timing and Interrupt Generator

This block keeps the raster position of a video display controller. A slot counter advances on each pixel-slot enable and a line counter advances partway through the line rather than at slot zero. The line-change slot is 132 when the narrow horizontal mode is selected and 165 when the wide mode is selected. The line counter does not count straight through: after the last line that is drawn it jumps forward to a high count, then climbs to the all-ones value and wraps to zero. This keeps the frame at the proper number of lines while the count stays 9 bits wide.

From this position the block raises two interrupt requests. One is a line-count interrupt, paced by a reload-and-decrement counter. The other is a once-per-frame vertical interrupt. Both are held pending until the processor acknowledges them. The block also drives a vertical-blank status bit whose edges fall two slots after the line boundary, and a frame counter. The 50 Hz / 60 Hz timing choice is taken from an input at reset and again each time the line counter wraps to zero. A change on that input in the middle of a frame therefore waits for the next frame.

Top module: `scan_timing_gen`

## Requirements
- R1: `slot` increments by one, modulo 256, on each clock with `slot_en` high, and holds its value otherwise.
- R2: `line` (9 bits, wrapping 0x1FF to 0) increments in the same clock edge that moves `slot` to the line-change slot: 132 when `wide`=0 and 165 when `wide`=1. `line` changes at no other time.
- R3: In 60 Hz timing the value after 0xEA is 0x1E5, not 0xEB. In 50 Hz timing the value after 0x102 is 0x1CA, not 0x103. The first blanked line is 224 (60 Hz) or 240 (50 Hz).
- R4: `pal`=1 selects 50 Hz timing. It is sampled during reset and in the edge where `line` becomes 0, and nowhere else.
- R5: At each line advance the new line value N is tested. If N is greater than the first blanked line, the line-interrupt counter reloads from `hint_reload`. Otherwise, if the counter is nonzero, it decrements. Otherwise `hint_pend` is raised and the counter reloads.
- R6: `vint_pend` is raised by a clock with `slot_en` high while `line` equals the first blanked line and `slot` equals 0.
- R7: Each pending flag stays set until its acknowledge input (`hint_ack`, `vint_ack`) is sampled high. A new trigger in the same clock as the acknowledge leaves the flag set.
- R8: `vblank` is 1 when any of these holds: `disp_en`=0; the line is above the first blanked line and below 0x1FF; the line is the first blanked line and the slot is at or past (line-change slot + 2) or below the line-change slot; the line is 0x1FF and the slot is at or past the line-change slot and below (line-change slot + 2).
- R9: `frame` increments by one, modulo 256, in the edge where `line` becomes the first blanked line plus 8.
- R10: While `rst_n` is low, `slot`, `line` and `frame` clear to 0, both pending flags clear, and the line-interrupt counter loads `hint_reload`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_en | input | 1 | Advance the slot position this clock |
| wide | input | 1 | 1 selects the wide horizontal mode, 0 the narrow mode |
| pal | input | 1 | 1 requests 50 Hz timing, 0 requests 60 Hz timing |
| disp_en | input | 1 | Display enable; 0 forces vertical blank |
| hint_reload | input | 8 | Reload value for the line-interrupt counter |
| hint_ack | input | 1 | Acknowledge for the line interrupt |
| vint_ack | input | 1 | Acknowledge for the vertical interrupt |
| slot | output | 8 | Horizontal slot position |
| line | output | 9 | Vertical line position |
| frame | output | 8 | Frame count |
| hint_pend | output | 1 | Line interrupt pending |
| vint_pend | output | 1 | Vertical interrupt pending |
| vblank | output | 1 | Vertical-blank status bit |

## Verification
The bench sweeps both horizontal modes and both timing standards. It raises the 50 Hz request in the middle of a 60 Hz frame, so a design that applied the request at once would skip the 0xEB-to-0x1E5 jump or take the wrong line as the first blanked line. It also holds both acknowledges high across trigger points; a design that let the acknowledge win would drop interrupts. It runs a zero reload value, where every drawn line must fire: a counter that decremented before testing for zero, or that tested the old line instead of the new one, would shift the interrupts by a line. Finally it walks the two-slot windows at the start and end of blanking, where an off-by-one slot comparison flips the status bit early or late.

// File: rtl/scan_pkg.sv
package scan_pkg;

   typedef enum logic {
      STD_60HZ = 1'b0,
      STD_50HZ = 1'b1
   } tv_std_e;

   typedef enum logic {
      HM_NARROW = 1'b0,
      HM_WIDE   = 1'b1
   } hmode_e;

endpackage

// File: rtl/scan_slot_ctr.sv
module scan_slot_ctr
   import scan_pkg::*;
#(
   parameter int unsigned SLOT_W    = 8,
   parameter int unsigned LC_WIDE   = 165,
   parameter int unsigned LC_NARROW = 132
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_en,
   input  hmode_e            hmode,
   output logic [SLOT_W-1:0] slot,
   output logic [SLOT_W-1:0] lc_slot,
   output logic              line_step
);

   localparam logic [SLOT_W-1:0] LC_W_V = SLOT_W'(LC_WIDE);
   localparam logic [SLOT_W-1:0] LC_N_V = SLOT_W'(LC_NARROW);

   logic [SLOT_W-1:0] slot_q;
   logic [SLOT_W-1:0] slot_inc;

   assign slot_inc  = slot_q + 1'b1;
   assign lc_slot   = (hmode == HM_WIDE) ? LC_W_V : LC_N_V;
   assign line_step = slot_en && (slot_inc == lc_slot);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (slot_en) begin
         slot_q <= slot_inc;
      end
   end

   assign slot = slot_q;

endmodule

// File: rtl/scan_line_ctr.sv
module scan_line_ctr
   import scan_pkg::*;
#(
   parameter int unsigned LINE_W         = 9,
   parameter int unsigned FRAME_W        = 8,
   parameter int unsigned INACT_60       = 224,
   parameter int unsigned INACT_50       = 240,
   parameter int unsigned JUMP_FROM_60   = 235,
   parameter int unsigned JUMP_TO_60     = 485,
   parameter int unsigned JUMP_FROM_50   = 259,
   parameter int unsigned JUMP_TO_50     = 458,
   parameter int unsigned FRAME_DELAY    = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_step,
   input  tv_std_e            std_req,
   output logic [LINE_W-1:0]  line,
   output logic [LINE_W-1:0]  line_nx,
   output logic [LINE_W-1:0]  inact_line,
   output tv_std_e            std_lat,
   output logic [FRAME_W-1:0] frame
);

   localparam logic [LINE_W-1:0] IN60_V = LINE_W'(INACT_60);
   localparam logic [LINE_W-1:0] IN50_V = LINE_W'(INACT_50);
   localparam logic [LINE_W-1:0] JF60_V = LINE_W'(JUMP_FROM_60);
   localparam logic [LINE_W-1:0] JT60_V = LINE_W'(JUMP_TO_60);
   localparam logic [LINE_W-1:0] JF50_V = LINE_W'(JUMP_FROM_50);
   localparam logic [LINE_W-1:0] JT50_V = LINE_W'(JUMP_TO_50);
   localparam logic [LINE_W-1:0] FT60_V = LINE_W'(INACT_60 + FRAME_DELAY);
   localparam logic [LINE_W-1:0] FT50_V = LINE_W'(INACT_50 + FRAME_DELAY);

   logic [LINE_W-1:0]  line_q;
   logic [LINE_W-1:0]  line_inc;
   logic [LINE_W-1:0]  jump_from;
   logic [LINE_W-1:0]  jump_to;
   logic [LINE_W-1:0]  frame_tick_line;
   logic [FRAME_W-1:0] frame_q;
   tv_std_e            std_q;

   always_comb begin
      line_inc = line_q + 1'b1;
      if (std_q == STD_50HZ) begin
         jump_from       = JF50_V;
         jump_to         = JT50_V;
         inact_line      = IN50_V;
         frame_tick_line = FT50_V;
      end else begin
         jump_from       = JF60_V;
         jump_to         = JT60_V;
         inact_line      = IN60_V;
         frame_tick_line = FT60_V;
      end
      line_nx = (line_inc == jump_from) ? jump_to : line_inc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q  <= '0;
         frame_q <= '0;
         std_q   <= std_req;
      end else if (line_step) begin
         line_q <= line_nx;
         if (line_nx == '0) begin
            std_q <= std_req;
         end
         if (line_nx == frame_tick_line) begin
            frame_q <= frame_q + 1'b1;
         end
      end
   end

   assign line    = line_q;
   assign std_lat = std_q;
   assign frame   = frame_q;

endmodule

// File: rtl/scan_hint.sv
module scan_hint #(
   parameter int unsigned LINE_W = 9,
   parameter int unsigned HREL_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_step,
   input  logic [LINE_W-1:0] line_nx,
   input  logic [LINE_W-1:0] inact_line,
   input  logic [HREL_W-1:0] reload,
   input  logic              ack,
   output logic              pend
);

   logic [HREL_W-1:0] cnt_q;
   logic              blank_line;
   logic              fire;
   logic              pend_q;

   assign blank_line = line_nx > inact_line;
   assign fire       = line_step && !blank_line && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= reload;
         pend_q <= 1'b0;
      end else begin
         if (line_step) begin
            if (blank_line || cnt_q == '0) begin
               cnt_q <= reload;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
         pend_q <= fire | (pend_q & ~ack);
      end
   end

   assign pend = pend_q;

endmodule

// File: rtl/scan_vert.sv
module scan_vert
   import scan_pkg::*;
#(
   parameter int unsigned SLOT_W      = 8,
   parameter int unsigned LINE_W      = 9,
   parameter int unsigned VINT_WIDE   = 0,
   parameter int unsigned VINT_NARROW = 0,
   parameter int unsigned VB_OFFSET   = 2,
   parameter bit          STATUS_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_en,
   input  hmode_e            hmode,
   input  logic              disp_en,
   input  logic [SLOT_W-1:0] slot,
   input  logic [SLOT_W-1:0] lc_slot,
   input  logic [LINE_W-1:0] line,
   input  logic [LINE_W-1:0] inact_line,
   input  logic              ack,
   output logic              pend,
   output logic              vblank
);

   localparam logic [SLOT_W-1:0] VS_W_V  = SLOT_W'(VINT_WIDE);
   localparam logic [SLOT_W-1:0] VS_N_V  = SLOT_W'(VINT_NARROW);
   localparam logic [SLOT_W-1:0] VB_OFF  = SLOT_W'(VB_OFFSET);
   localparam logic [LINE_W-1:0] LAST_LN = '1;

   logic [SLOT_W-1:0] vint_slot;
   logic [SLOT_W-1:0] vb_start;
   logic              vfire;
   logic              pend_q;
   logic              mid_blank;
   logic              head_blank;
   logic              tail_blank;
   logic              vb_now;

   assign vint_slot = (hmode == HM_WIDE) ? VS_W_V : VS_N_V;
   assign vb_start  = lc_slot + VB_OFF;
   assign vfire     = slot_en && (line == inact_line) && (slot == vint_slot);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else begin
         pend_q <= vfire | (pend_q & ~ack);
      end
   end

   assign pend = pend_q;

   always_comb begin
      mid_blank  = (line > inact_line) && (line < LAST_LN);
      head_blank = (line == inact_line) && ((slot >= vb_start) || (slot < lc_slot));
      tail_blank = (line == LAST_LN) && (slot >= lc_slot) && (slot < vb_start);
      vb_now     = mid_blank || head_blank || tail_blank || !disp_en;
   end

   generate
      if (STATUS_REG) begin : g_vb_reg
         logic vb_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vb_q <= 1'b0;
            end else begin
               vb_q <= vb_now;
            end
         end
         assign vblank = vb_q;
      end else begin : g_vb_comb
         assign vblank = vb_now;
      end
   endgenerate

endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
   import scan_pkg::*;
#(
   parameter int unsigned SLOT_W       = 8,
   parameter int unsigned LINE_W       = 9,
   parameter int unsigned FRAME_W      = 8,
   parameter int unsigned HREL_W       = 8,
   parameter int unsigned LC_WIDE      = 165,
   parameter int unsigned LC_NARROW    = 132,
   parameter int unsigned VB_OFFSET    = 2,
   parameter int unsigned VINT_WIDE    = 0,
   parameter int unsigned VINT_NARROW  = 0,
   parameter int unsigned INACT_60     = 224,
   parameter int unsigned INACT_50     = 240,
   parameter int unsigned JUMP_FROM_60 = 235,
   parameter int unsigned JUMP_TO_60   = 485,
   parameter int unsigned JUMP_FROM_50 = 259,
   parameter int unsigned JUMP_TO_50   = 458,
   parameter int unsigned FRAME_DELAY  = 8,
   parameter bit          STATUS_REG   = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               slot_en,
   input  logic               wide,
   input  logic               pal,
   input  logic               disp_en,
   input  logic [HREL_W-1:0]  hint_reload,
   input  logic               hint_ack,
   input  logic               vint_ack,
   output logic [SLOT_W-1:0]  slot,
   output logic [LINE_W-1:0]  line,
   output logic [FRAME_W-1:0] frame,
   output logic               hint_pend,
   output logic               vint_pend,
   output logic               vblank
);

   localparam int unsigned SLOTS = 1 << SLOT_W;
   localparam int unsigned LINES = 1 << LINE_W;

   generate
      if (LC_WIDE + VB_OFFSET >= SLOTS || LC_NARROW + VB_OFFSET >= SLOTS) begin : g_bad_lc
         $error("line-change slot plus blank offset exceeds slot range");
      end
      if (VINT_WIDE >= SLOTS || VINT_NARROW >= SLOTS) begin : g_bad_vs
         $error("vertical interrupt slot exceeds slot range");
      end
      if (JUMP_TO_60 <= JUMP_FROM_60 || JUMP_TO_50 <= JUMP_FROM_50 ||
          JUMP_TO_60 >= LINES || JUMP_TO_50 >= LINES) begin : g_bad_jump
         $error("line jump must go forward inside the line range");
      end
      if (INACT_60 + FRAME_DELAY >= JUMP_FROM_60 ||
          INACT_50 + FRAME_DELAY >= JUMP_FROM_50) begin : g_bad_inact
         $error("frame tick line must precede the line jump");
      end
   endgenerate

   hmode_e            hmode;
   tv_std_e           std_req;
   tv_std_e           std_lat;
   logic [SLOT_W-1:0] lc_slot;
   logic              line_step;
   logic [LINE_W-1:0] line_nx;
   logic [LINE_W-1:0] inact_line;

   assign hmode   = hmode_e'(wide);
   assign std_req = tv_std_e'(pal);

   scan_slot_ctr #(
      .SLOT_W    (SLOT_W),
      .LC_WIDE   (LC_WIDE),
      .LC_NARROW (LC_NARROW)
   ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_en   (slot_en),
      .hmode     (hmode),
      .slot      (slot),
      .lc_slot   (lc_slot),
      .line_step (line_step)
   );

   scan_line_ctr #(
      .LINE_W       (LINE_W),
      .FRAME_W      (FRAME_W),
      .INACT_60     (INACT_60),
      .INACT_50     (INACT_50),
      .JUMP_FROM_60 (JUMP_FROM_60),
      .JUMP_TO_60   (JUMP_TO_60),
      .JUMP_FROM_50 (JUMP_FROM_50),
      .JUMP_TO_50   (JUMP_TO_50),
      .FRAME_DELAY  (FRAME_DELAY)
   ) u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_step  (line_step),
      .std_req    (std_req),
      .line       (line),
      .line_nx    (line_nx),
      .inact_line (inact_line),
      .std_lat    (std_lat),
      .frame      (frame)
   );

   scan_hint #(
      .LINE_W (LINE_W),
      .HREL_W (HREL_W)
   ) u_hint (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_step  (line_step),
      .line_nx    (line_nx),
      .inact_line (inact_line),
      .reload     (hint_reload),
      .ack        (hint_ack),
      .pend       (hint_pend)
   );

   scan_vert #(
      .SLOT_W      (SLOT_W),
      .LINE_W      (LINE_W),
      .VINT_WIDE   (VINT_WIDE),
      .VINT_NARROW (VINT_NARROW),
      .VB_OFFSET   (VB_OFFSET),
      .STATUS_REG  (STATUS_REG)
   ) u_vert (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_en    (slot_en),
      .hmode      (hmode),
      .disp_en    (disp_en),
      .slot       (slot),
      .lc_slot    (lc_slot),
      .line       (line),
      .inact_line (inact_line),
      .ack        (vint_ack),
      .pend       (vint_pend),
      .vblank     (vblank)
   );

endmodule

// File: rtl/scan_timing_chk.sv
module scan_timing_chk #(
   parameter int unsigned SLOT_W       = 8,
   parameter int unsigned LINE_W       = 9,
   parameter int unsigned FRAME_W      = 8,
   parameter int unsigned LC_WIDE      = 165,
   parameter int unsigned LC_NARROW    = 132,
   parameter int unsigned JUMP_FROM_60 = 235,
   parameter int unsigned JUMP_TO_60   = 485
) (
   input logic               clk,
   input logic               rst_n,
   input logic               slot_en,
   input logic               wide,
   input logic               hint_ack,
   input logic               vint_ack,
   input logic               std_lat,
   input logic [SLOT_W-1:0]  slot,
   input logic [LINE_W-1:0]  line,
   input logic [FRAME_W-1:0] frame,
   input logic               hint_pend,
   input logic               vint_pend,
   input logic               vblank
);

   localparam logic [SLOT_W-1:0] LCW = SLOT_W'(LC_WIDE);
   localparam logic [SLOT_W-1:0] LCN = SLOT_W'(LC_NARROW);
   localparam logic [LINE_W-1:0] JF  = LINE_W'(JUMP_FROM_60);
   localparam logic [LINE_W-1:0] JT  = LINE_W'(JUMP_TO_60);

   AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_en |=> $stable(slot)); // R1

   AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      slot_en |=> (slot == $past(slot) + 1'b1)); // R1

   AST_LINE_AT_CHANGE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(line) |-> (slot == ($past(wide) ? LCW : LCN))); // R2

   AST_NO_SKIPPED_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      !std_lat |-> !((line >= JF) && (line < JT))); // R3

   AST_HINT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hint_pend) |-> $past(hint_ack)); // R7

   AST_VINT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vint_pend) |-> $past(vint_ack)); // R7

   AST_VINT_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vint_pend) |-> vblank); // R8

   AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(frame) |-> (frame == $past(frame) + 1'b1)); // R9

endmodule

bind scan_timing_gen scan_timing_chk #(
   .SLOT_W       (SLOT_W),
   .LINE_W       (LINE_W),
   .FRAME_W      (FRAME_W),
   .LC_WIDE      (LC_WIDE),
   .LC_NARROW    (LC_NARROW),
   .JUMP_FROM_60 (JUMP_FROM_60),
   .JUMP_TO_60   (JUMP_TO_60)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .slot_en   (slot_en),
   .wide      (wide),
   .hint_ack  (hint_ack),
   .vint_ack  (vint_ack),
   .std_lat   (std_lat),
   .slot      (slot),
   .line      (line),
   .frame     (frame),
   .hint_pend (hint_pend),
   .vint_pend (vint_pend),
   .vblank    (vblank)
);

// File: tb/sim_scan_timing_gen.sv
`timescale 1ns/1ps
module sim_scan_timing_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       slot_en = 1'b0;
   logic       wide = 1'b0;
   logic       pal = 1'b0;
   logic       disp_en = 1'b1;
   logic [7:0] hint_reload = 8'd3;
   logic       hint_ack = 1'b0;
   logic       vint_ack = 1'b0;
   logic [7:0] slot;
   logic [8:0] line;
   logic [7:0] frame;
   logic       hint_pend;
   logic       vint_pend;
   logic       vblank;

   always #2.5 clk = ~clk;

   scan_timing_gen u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .slot_en     (slot_en),
      .wide        (wide),
      .pal         (pal),
      .disp_en     (disp_en),
      .hint_reload (hint_reload),
      .hint_ack    (hint_ack),
      .vint_ack    (vint_ack),
      .slot        (slot),
      .line        (line),
      .frame       (frame),
      .hint_pend   (hint_pend),
      .vint_pend   (vint_pend),
      .vblank      (vblank)
   );

   int vectors = 0;
   int fails   = 0;
   bit started = 0;
   bit done    = 0;

   // behavioural reference state
   int m_slot, m_line, m_frame, m_hcnt, m_pal, m_hp, m_vp;
   int m_wraps = 0;
   int m_nl, m_vf, m_hf;

   function automatic int lc_of(bit w);
      return w ? 165 : 132;
   endfunction

   function automatic int inact_of(int p);
      return p ? 240 : 224;
   endfunction

   function automatic int vb_expect(int ln, int sl, bit w, bit de, int p);
      int lc, vs, ia;
      lc = lc_of(w);
      vs = lc + 2;
      ia = inact_of(p);
      if (!de) return 1;
      if (ln > ia && ln < 511) return 1;
      if (ln == ia && (sl >= vs || sl < lc)) return 1;
      if (ln == 511 && sl >= lc && sl < vs) return 1;
      return 0;
   endfunction

   always @(posedge clk) begin
      started = 1;
      if (!rst_n) begin
         m_slot = 0; m_line = 0; m_frame = 0;
         m_hcnt = hint_reload; m_pal = pal; m_hp = 0; m_vp = 0;
      end else begin
         m_vf = 0;
         m_hf = 0;
         if (slot_en) begin
            if (m_line == inact_of(m_pal) && m_slot == 0) m_vf = 1;
            m_slot = (m_slot + 1) % 256;
            if (m_slot == lc_of(wide)) begin
               m_nl = (m_line + 1) % 512;
               if (!m_pal && m_nl == 235) m_nl = 485;
               if (m_pal && m_nl == 259) m_nl = 458;
               if (m_nl > inact_of(m_pal)) m_hcnt = hint_reload;
               else if (m_hcnt > 0) m_hcnt = m_hcnt - 1;
               else begin m_hf = 1; m_hcnt = hint_reload; end
               if (m_nl == inact_of(m_pal) + 8) m_frame = (m_frame + 1) % 256;
               m_line = m_nl;
               if (m_nl == 0) begin m_pal = pal; m_wraps++; end
            end
         end
         m_hp = m_hf | (m_hp & !hint_ack);
         m_vp = m_vf | (m_vp & !vint_ack);
      end
   end

   task automatic check(string tag, int act, int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (started && !done) begin
         check("R1 slot", slot, m_slot);
         check("R2 R3 R4 line", line, m_line);
         check("R9 frame", frame, m_frame);
         check("R5 R7 hint_pend", hint_pend, m_hp);
         check("R6 R7 vint_pend", vint_pend, m_vp);
         check("R8 vblank", vblank, vb_expect(m_line, m_slot, wide, disp_en, m_pal));
      end
   end

   task automatic summary();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (4) @(posedge clk);
      #1;
      // R10: reset state seen at the ports
      check("R10 reset slot", slot, 0);
      check("R10 reset line", line, 0);
      check("R10 reset frame", frame, 0);
      check("R10 reset pend", {hint_pend, vint_pend}, 0);
      rst_n = 1'b1;

      // narrow mode, gapped slot enables, random acknowledges, display off window
      for (int i = 0; i < 8000; i++) begin
         @(posedge clk); #1;
         slot_en  = ($urandom % 4) != 0;
         hint_ack = ($urandom % 8) == 0;
         vint_ack = ($urandom % 8) == 0;
         disp_en  = !(i >= 3000 && i < 3600);
      end

      // wide mode, 50 Hz requested mid-frame: must wait for line 0 (R4)
      @(posedge clk); #1;
      wide    = 1'b1;
      slot_en = 1'b1;
      pal     = 1'b1;
      while (m_wraps < 1) begin
         @(posedge clk); #1;
         hint_ack = ($urandom % 16) == 0;
         vint_ack = ($urandom % 16) == 0;
      end
      // R3: first line of the new frame under 50 Hz
      check("R3 R4 wrap to zero", line, 0);
      hint_reload = 8'd0;
      for (int i = 0; i < 4000; i++) begin
         @(posedge clk); #1;
         hint_ack = 1'b1;   // R7: trigger wins over a held acknowledge
         vint_ack = 1'b1;
      end
      while (m_wraps < 2) begin
         @(posedge clk); #1;
         hint_ack = ($urandom % 16) == 0;
         vint_ack = ($urandom % 16) == 0;
         slot_en  = ($urandom % 32) != 0;
         disp_en  = ($urandom % 64) != 0;
      end
      repeat (300) @(posedge clk);
      #1;
      summary();
   end

endmodule